// File: doc/BRIEF.md
# Dual-Line Synchronous Serial Transmitter

This block takes parallel words from a host write port and sends them out MSB first on two serial data lines, primary and secondary. Both lines share one serial clock and one frame-sync pin. Each host write carries one word for each line. The pair is queued in a slot store whose shape follows the programmed word length. From there it moves through a per-line hold register into a per-line shift register.

The serial clock can be generated internally by dividing the system clock, in which case it is driven out. It can also be taken from an external pin. Once the first word has started, the port streams without gaps. When no new word is waiting at a word boundary, it sends the previous word again and records an underflow.

In multichannel mode the frame-sync pin becomes a data-valid indicator. The word length is captured only while the port is disabled. Moving between the short-word and long-word storage shapes empties the queue.

Top module: `dual_serial_tx`

## Requirements
- R1: With length code L (2 to 31) each line sends exactly L+1 bits per word, MSB (bit L) first; written bits above bit L never appear on the lines.
- R2: For L from 2 to 15 the store holds 8 words of 16 bits, and for L from 16 to 31 it holds 4 words of 32 bits. With the hold register, 9 or 5 writes respectively are accepted from empty on a disabled port before the store is full.
- R3: A write while the store is full is dropped, and the sticky overflow output rises one clock later and stays high until reset.
- R4: Outside multichannel mode the frame-sync pin is high for exactly one serial-clock period, the one just before a word's first bit. In a continuous stream this period coincides with the previous word's last bit.
- R5: The primary and secondary lines send their own words of the same write in lockstep, bit for bit in the same serial-clock periods.
- R6: With the internal clock selected, the serial clock period is 2×(D+1) system clocks for divider value D, and the data lines change on its falling edge. The clock-drive enable output is high while the port is enabled.
- R7: With the external clock selected, the clock-drive enable output is low, the generated clock stays low, and the data lines change after falling edges of the external clock input.
- R8: When a word ends and no new word is waiting, the same word pair is sent again and the sticky underflow output is set.
- R9: In multichannel mode the frame-sync pin is high exactly in the serial-clock periods that carry data bits, and low in the period before the first word.
- R10: The length code is captured only while the port is disabled; changing it while enabled has no effect on the word length.
- R11: Changing the length code between the short and long ranges while disabled empties both the store and the hold registers.
- R12: After reset, and whenever the port is disabled, the data lines, the frame-sync pin and the generated clock are low. After reset both sticky flags are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Port enable; low stops the serial side and allows length capture |
| wordLenCode | input | LEN_W | Word length minus one (2 to 31) |
| clkDiv | input | DIV_W | Internal serial clock divider value D |
| extClkSel | input | 1 | 1 selects the external serial clock |
| multiChan | input | 1 | 1 turns the frame-sync pin into a data-valid pin |
| sclkIn | input | 1 | External serial clock |
| wrValid | input | 1 | Host write strobe, one word pair per cycle |
| wrPri | input | 2*SLOT_W | Word for the primary line |
| wrSec | input | 2*SLOT_W | Word for the secondary line |
| sclkOut | output | 1 | Generated serial clock |
| sclkOe | output | 1 | Drive enable for the serial clock pin |
| fsPin | output | 1 | Frame sync, or data valid in multichannel mode |
| dPri | output | 1 | Primary serial data |
| dSec | output | 1 | Secondary serial data |
| overflow | output | 1 | Sticky flag for a dropped write |
| underflow | output | 1 | Sticky flag for a retransmitted word |

## Verification
A write changes the queue occupancy at the next clock, so the overflow flag is checked a few clocks after the offending write. Serial outputs change on a falling serial-clock edge: the same system clock with the internal clock, and about three system clocks later with the external one, after the synchroniser and edge detector. The bench therefore samples data and frame sync only when it sees a rising serial-clock edge, half a serial period after any change. It rebuilds words from those samples and waits for a word count rather than a fixed cycle number. The clock period is measured between consecutive rising edges.

// File: rtl/dstx_pkg.sv
package dstx_pkg;

  // Strobes from the timing control to the datapath, valid for one clock.
  typedef struct packed {
    logic clearOut;   // port disabled: force serial lines low
    logic shiftBit;   // drive the next bit of the current word
    logic loadWord;   // bring the next word (or a repeat) into the shifters
  } dstx_strobe_t;

endpackage

// File: rtl/dstx_ctrl.sv
module dstx_ctrl
  import dstx_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int LEN_W   = 5,
  parameter int LEN_MIN = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             extClkSel,
  input  logic             multiChan,
  input  logic             sclkIn,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [LEN_W-1:0] wordLenCode,
  input  logic             holdValid,
  output logic [LEN_W-1:0] lenEff,
  output dstx_strobe_t     strobe,
  output logic             sclkOut,
  output logic             sclkOe,
  output logic             fsPin
);

  localparam int REM_W = LEN_W + 1;

  logic [DIV_W-1:0] divCnt;
  logic             sclkReg;
  logic [2:0]       extSync;
  logic             intTick, extTick, tick;
  logic             running;
  logic [REM_W-1:0] remain;
  logic             fsReg, dvReg;
  logic             lastBit;

  // Internal divider: toggles every clkDiv+1 clocks.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      sclkReg <= 1'b0;
    end else if (!enable || extClkSel) begin
      divCnt  <= '0;
      sclkReg <= 1'b0;
    end else if (divCnt == clkDiv) begin
      divCnt  <= '0;
      sclkReg <= ~sclkReg;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // External clock: two-flop synchroniser plus one delayed copy.
  always_ff @(posedge clk) begin
    if (!rstN) extSync <= '0;
    else       extSync <= {extSync[1:0], sclkIn};
  end

  assign intTick = enable && !extClkSel && (divCnt == clkDiv) && sclkReg;
  assign extTick = enable && extClkSel && extSync[2] && !extSync[1];
  assign tick    = intTick || extTick;

  // Length capture only while disabled, clamped to the minimum.
  always_ff @(posedge clk) begin
    if (!rstN)
      lenEff <= LEN_W'(LEN_MIN);
    else if (!enable)
      lenEff <= (wordLenCode < LEN_W'(LEN_MIN)) ? LEN_W'(LEN_MIN) : wordLenCode;
  end

  assign lastBit = (remain == REM_W'(1));

  // Word sequencing on driving-edge ticks.
  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      running <= 1'b0;
      remain  <= '0;
      fsReg   <= 1'b0;
      dvReg   <= 1'b0;
    end else if (tick) begin
      if (!running) begin
        if (holdValid) begin
          running <= 1'b1;
          remain  <= {1'b0, lenEff} + REM_W'(1);
          fsReg   <= 1'b1;
          dvReg   <= 1'b0;
        end
      end else begin
        dvReg <= 1'b1;
        if (lastBit) begin
          remain <= {1'b0, lenEff} + REM_W'(1);
          fsReg  <= 1'b1;
        end else begin
          remain <= remain - REM_W'(1);
          fsReg  <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.clearOut = !enable;
    strobe.shiftBit = tick && running;
    strobe.loadWord = tick && ((!running && holdValid) || (running && lastBit));
  end

  assign sclkOut = sclkReg;
  assign sclkOe  = enable && !extClkSel;
  assign fsPin   = multiChan ? dvReg : fsReg;

  // R4: a frame-sync period never extends over two ticks.
  p_fs_one_period_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && fsReg) |=> !fsReg);

  // R10: the captured length holds while the port stays enabled.
  p_len_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> (!enable || $stable(lenEff)));

  // R12: a disabled port leaves the serial side quiet.
  p_quiet_off_r12: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!fsReg && !dvReg && !sclkReg && !running));

endmodule

// File: rtl/dstx_datapath.sv
module dstx_datapath
  import dstx_pkg::*;
#(
  parameter int SLOT_W = 16,
  parameter int SLOTS  = 8,
  parameter int LEN_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  dstx_strobe_t        strobe,
  input  logic [LEN_W-1:0]    lenEff,
  input  logic                wrValid,
  input  logic [2*SLOT_W-1:0] wrPri,
  input  logic [2*SLOT_W-1:0] wrSec,
  output logic                holdValid,
  output logic                dPri,
  output logic                dSec,
  output logic                overflow,
  output logic                underflow
);

  localparam int WORD_W = 2 * SLOT_W;
  localparam int LANES  = 2;
  localparam int PTR_W  = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(SLOTS + 1);

  logic             wide, widePrev, flush;
  logic [CNT_W-1:0] depthNow, count;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             full, doWrite, pop;

  logic [SLOT_W-1:0] mem      [LANES][SLOTS];
  logic [WORD_W-1:0] laneIn   [LANES];
  logic [WORD_W-1:0] rdWord   [LANES];
  logic [WORD_W-1:0] hold     [LANES];
  logic [WORD_W-1:0] shReg    [LANES];
  logic [WORD_W-1:0] lastWord [LANES];
  logic [WORD_W-1:0] nextWord [LANES];
  logic [LANES-1:0]  dOut;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p,
                                               input logic [CNT_W-1:0] depth);
    return (CNT_W'(p) == depth - CNT_W'(1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign laneIn[0] = wrPri;
  assign laneIn[1] = wrSec;

  // Storage geometry follows the captured word length.
  assign wide     = (lenEff >= LEN_W'(SLOT_W));
  assign depthNow = wide ? CNT_W'(SLOTS / 2) : CNT_W'(SLOTS);
  assign flush    = (wide != widePrev);
  assign full     = (count == depthNow);
  assign doWrite  = wrValid && !full && !flush;
  assign pop      = (!holdValid || strobe.loadWord) && (count != '0) && !flush;

  always_ff @(posedge clk) begin
    if (!rstN) widePrev <= 1'b0;
    else       widePrev <= wide;
  end

  // Slot store: a long entry uses an even/odd slot pair.
  always_ff @(posedge clk) begin
    if (doWrite) begin
      for (int l = 0; l < LANES; l++) begin
        if (wide) begin
          mem[l][{wrPtr[PTR_W-2:0], 1'b0}] <= laneIn[l][SLOT_W-1:0];
          mem[l][{wrPtr[PTR_W-2:0], 1'b1}] <= laneIn[l][WORD_W-1:SLOT_W];
        end else begin
          mem[l][wrPtr] <= laneIn[l][SLOT_W-1:0];
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign rdWord[g] = wide ?
        {mem[g][{rdPtr[PTR_W-2:0], 1'b1}], mem[g][{rdPtr[PTR_W-2:0], 1'b0}]} :
        {{SLOT_W{1'b0}}, mem[g][rdPtr]};
      assign nextWord[g] = holdValid ? hold[g] : lastWord[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWrite) wrPtr <= advance(wrPtr, depthNow);
      if (pop)     rdPtr <= advance(rdPtr, depthNow);
      count <= count + CNT_W'(doWrite) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) overflow <= 1'b0;
    else if (wrValid && full && !flush) overflow <= 1'b1;
  end

  // Hold stage.
  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      holdValid <= 1'b0;
      for (int l = 0; l < LANES; l++) hold[l] <= '0;
    end else if (pop) begin
      holdValid <= 1'b1;
      for (int l = 0; l < LANES; l++) hold[l] <= rdWord[l];
    end else if (strobe.loadWord) begin
      holdValid <= 1'b0;
    end
  end

  // Shift stage: the bit at the captured length is the one driven out.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dOut      <= '0;
      underflow <= 1'b0;
      for (int l = 0; l < LANES; l++) begin
        shReg[l]    <= '0;
        lastWord[l] <= '0;
      end
    end else if (strobe.clearOut) begin
      dOut <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (strobe.shiftBit) dOut[l] <= shReg[l][lenEff];
        if (strobe.loadWord) begin
          shReg[l]    <= nextWord[l];
          lastWord[l] <= nextWord[l];
        end else if (strobe.shiftBit) begin
          shReg[l] <= shReg[l] << 1;
        end
      end
      if (strobe.loadWord && !holdValid) underflow <= 1'b1;
    end
  end

  assign dPri = dOut[0];
  assign dSec = dOut[1];

  // R2: occupancy never exceeds the depth of the current geometry.
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= depthNow);

  // R3: a write into a full store leaves the occupancy untouched.
  p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && full && !pop && !flush) |=> $stable(count));

  // R3: overflow is sticky.
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R8: underflow is sticky.
  p_udf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> underflow);

  // R11: a geometry change leaves nothing queued.
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0 && !holdValid));

endmodule

// File: rtl/dual_serial_tx.sv
module dual_serial_tx
  import dstx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int SLOT_W = 16,
  parameter int SLOTS  = 8,
  localparam int WORD_W = 2 * SLOT_W,
  localparam int LEN_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [LEN_W-1:0]  wordLenCode,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              extClkSel,
  input  logic              multiChan,
  input  logic              sclkIn,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrPri,
  input  logic [WORD_W-1:0] wrSec,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              fsPin,
  output logic              dPri,
  output logic              dSec,
  output logic              overflow,
  output logic              underflow
);

  dstx_strobe_t     strobe;
  logic [LEN_W-1:0] lenEff;
  logic             holdValid;

  dstx_ctrl #(
    .DIV_W (DIV_W),
    .LEN_W (LEN_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .extClkSel   (extClkSel),
    .multiChan   (multiChan),
    .sclkIn      (sclkIn),
    .clkDiv      (clkDiv),
    .wordLenCode (wordLenCode),
    .holdValid   (holdValid),
    .lenEff      (lenEff),
    .strobe      (strobe),
    .sclkOut     (sclkOut),
    .sclkOe      (sclkOe),
    .fsPin       (fsPin)
  );

  dstx_datapath #(
    .SLOT_W (SLOT_W),
    .SLOTS  (SLOTS),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lenEff    (lenEff),
    .wrValid   (wrValid),
    .wrPri     (wrPri),
    .wrSec     (wrSec),
    .holdValid (holdValid),
    .dPri      (dPri),
    .dSec      (dSec),
    .overflow  (overflow),
    .underflow (underflow)
  );

endmodule

// File: tb/sim_dual_serial_tx.sv
module sim_dual_serial_tx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [4:0]  wordLenCode = 5'd7;
  logic [7:0]  clkDiv = 8'd1;
  logic        extClkSel = 1'b0;
  logic        multiChan = 1'b0;
  logic        sclkIn = 1'b0;
  logic        wrValid = 1'b0;
  logic [31:0] wrPri = '0;
  logic [31:0] wrSec = '0;
  logic        sclkOut, sclkOe, fsPin, dPri, dSec, overflow, underflow;

  dual_serial_tx u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .wordLenCode(wordLenCode),
    .clkDiv(clkDiv), .extClkSel(extClkSel), .multiChan(multiChan),
    .sclkIn(sclkIn), .wrValid(wrValid), .wrPri(wrPri), .wrSec(wrSec),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .fsPin(fsPin), .dPri(dPri),
    .dSec(dSec), .overflow(overflow), .underflow(underflow)
  );

  always #4 clk = ~clk;  // 125 MHz

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // Monitor state.
  int          cyc = 0;
  logic        obsPrev = 1'b0;
  bit          extMode = 1'b0;
  bit          monMulti = 1'b0;
  int          monLen = 8;
  int          bitsLeft = 0;
  int          gotBits = 0;
  logic [31:0] curP = '0, curS = '0;
  logic        prevFs = 1'b0;
  int          fsDouble = 0;
  int          lastRise = 0;
  int          period = 0;
  int          rxCount = 0;
  logic [31:0] rxP [64];
  logic [31:0] rxS [64];
  logic [31:0] expP [16];
  logic [31:0] expS [16];
  bit          extRun = 1'b0;

  always @(negedge clk) begin
    logic obs;
    cyc++;
    obs = extMode ? sclkIn : sclkOut;
    if (obs && !obsPrev) begin
      period   = cyc - lastRise;
      lastRise = cyc;
      if (monMulti) begin
        if (fsPin) begin
          curP = {curP[30:0], dPri};
          curS = {curS[30:0], dSec};
          gotBits++;
          if (gotBits == monLen) begin
            if (rxCount < 64) begin rxP[rxCount] = curP; rxS[rxCount] = curS; end
            rxCount++;
            gotBits = 0; curP = '0; curS = '0;
          end
        end
      end else begin
        if (bitsLeft > 0) begin
          curP = {curP[30:0], dPri};
          curS = {curS[30:0], dSec};
          bitsLeft--;
          if (bitsLeft == 0) begin
            if (rxCount < 64) begin rxP[rxCount] = curP; rxS[rxCount] = curS; end
            rxCount++;
          end
        end
        if (fsPin) begin
          if (prevFs) fsDouble++;
          bitsLeft = monLen; curP = '0; curS = '0;
        end
        prevFs = fsPin;
      end
    end
    obsPrev = obs;
  end

  // External serial clock source: half period of 6 system clocks.
  initial begin
    int t = 0;
    forever begin
      @(posedge clk); #1;
      if (extRun) begin
        t++;
        if (t == 6) begin t = 0; sclkIn = ~sclkIn; end
      end else begin
        t = 0; sclkIn = 1'b0;
      end
    end
  end

  // Watchdog.
  initial begin
    wait (cyc > 150000);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] genP(input int l, input int k);
    return 32'hA5C3_96E1 ^ (32'(l) * 32'h0101_0101) ^ (32'(k) * 32'h0003_B1D7);
  endfunction

  function automatic logic [31:0] genS(input int l, input int k);
    logic [31:0] p;
    p = genP(l, k);
    return {p[15:0], p[31:16]} ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] maskOf(input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doReset(input int l);
    @(posedge clk); #1;
    rstN = 1'b0; enable = 1'b0; wrValid = 1'b0; extRun = 1'b0;
    extClkSel = 1'b0; multiChan = 1'b0; wordLenCode = 5'(l);
    cycles(3);
    rstN = 1'b1;
    rxCount = 0; bitsLeft = 0; gotBits = 0; fsDouble = 0; prevFs = 1'b0;
    extMode = 1'b0; monMulti = 1'b0; monLen = l + 1;
    cycles(4);
  endtask

  task automatic writeWord(input logic [31:0] p, input logic [31:0] s);
    @(posedge clk); #1;
    wrValid = 1'b1; wrPri = p; wrSec = s;
    @(posedge clk); #1;
    wrValid = 1'b0;
  endtask

  task automatic fillWords(input int l, input int n);
    for (int k = 0; k < n; k++) begin
      expP[k] = genP(l, k);
      expS[k] = genS(l, k);
      writeWord(expP[k], expS[k]);
    end
  endtask

  task automatic waitWords(input int n);
    int t = 0;
    while (rxCount < n && t < 20000) begin
      @(posedge clk); t++;
    end
    #1;
  endtask

  task automatic cmpWord(input int rxIdx, input int expIdx, input string req);
    logic [31:0] m;
    m = maskOf(monLen);
    check(rxP[rxIdx] == (expP[expIdx] & m), req, 64'(rxP[rxIdx]), 64'(expP[expIdx] & m));
    check(rxS[rxIdx] == (expS[expIdx] & m), req, 64'(rxS[rxIdx]), 64'(expS[expIdx] & m));
  endtask

  initial begin
    // R12: reset state.
    doReset(7);
    check(fsPin == 1'b0 && dPri == 1'b0 && dSec == 1'b0, "R12 lines low",
          64'({fsPin, dPri, dSec}), 64'd0);
    check(sclkOut == 1'b0 && sclkOe == 1'b0, "R12 clock idle",
          64'({sclkOut, sclkOe}), 64'd0);
    check(overflow == 1'b0 && underflow == 1'b0, "R12 flags clear",
          64'({overflow, underflow}), 64'd0);

    // R1, R5, R6, R4, R8: sweep every length code.
    for (int l = 2; l <= 31; l++) begin
      doReset(l);
      clkDiv = 8'(l % 3);
      fillWords(l, 3);
      check(underflow == 1'b0, "R8 no underflow before start", 64'(underflow), 64'd0);
      enable = 1'b1;
      cycles(2);
      check(sclkOe == 1'b1, "R6 clock driven", 64'(sclkOe), 64'd1);
      waitWords(4);
      for (int k = 0; k < 3; k++) cmpWord(k, k, $sformatf("R1,R5 len %0d word %0d", l + 1, k));
      cmpWord(3, 2, $sformatf("R8 repeat len %0d", l + 1));
      check(underflow == 1'b1, "R8 underflow set", 64'(underflow), 64'd1);
      check(period == 2 * ((l % 3) + 1), "R6 clock period", 64'(period),
            64'(2 * ((l % 3) + 1)));
      check(fsDouble == 0, "R4 frame sync width", 64'(fsDouble), 64'd0);
      enable = 1'b0;
      cycles(2);
      check(fsPin == 1'b0 && dPri == 1'b0 && dSec == 1'b0 && sclkOut == 1'b0,
            "R12 quiet when disabled", 64'({fsPin, dPri, dSec, sclkOut}), 64'd0);
    end

    // R2, R3: short geometry, 8 slots plus hold.
    doReset(7);
    clkDiv = 8'd1;
    fillWords(7, 9);
    cycles(3);
    check(overflow == 1'b0, "R2 nine short writes fit", 64'(overflow), 64'd0);
    writeWord(32'hDEAD_BEEF, 32'hCAFE_F00D);
    cycles(2);
    check(overflow == 1'b1, "R3 overflow on tenth", 64'(overflow), 64'd1);
    enable = 1'b1;
    waitWords(10);
    for (int k = 0; k < 9; k++) cmpWord(k, k, $sformatf("R2 short word %0d", k));
    cmpWord(9, 8, "R3 dropped word absent");
    check(overflow == 1'b1, "R3 overflow sticky", 64'(overflow), 64'd1);

    // R2, R3: long geometry, 4 entries plus hold.
    doReset(23);
    fillWords(23, 5);
    cycles(3);
    check(overflow == 1'b0, "R2 five long writes fit", 64'(overflow), 64'd0);
    writeWord(32'h1234_5678, 32'h8765_4321);
    cycles(2);
    check(overflow == 1'b1, "R3 overflow on sixth", 64'(overflow), 64'd1);
    enable = 1'b1;
    waitWords(6);
    for (int k = 0; k < 5; k++) cmpWord(k, k, $sformatf("R2 long word %0d", k));
    cmpWord(5, 4, "R3 long dropped word absent");

    // R11: geometry change while disabled flushes.
    doReset(7);
    fillWords(7, 3);
    cycles(4);
    wordLenCode = 5'd23;
    cycles(4);
    monLen = 24;
    fillWords(23, 2);
    enable = 1'b1;
    waitWords(3);
    cmpWord(0, 0, "R11 first word after flush");
    cmpWord(1, 1, "R11 second word after flush");
    cmpWord(2, 1, "R11 nothing stale left");

    // R10: length change while enabled ignored.
    doReset(7);
    fillWords(7, 4);
    enable = 1'b1;
    waitWords(1);
    wordLenCode = 5'd12;
    waitWords(5);
    for (int k = 1; k < 4; k++) cmpWord(k, k, $sformatf("R10 length held word %0d", k));
    cmpWord(4, 3, "R10 length held repeat");

    // R9: multichannel data-valid.
    doReset(5);
    multiChan = 1'b1;
    monMulti = 1'b1;
    cycles(2);
    check(fsPin == 1'b0, "R9 valid low before start", 64'(fsPin), 64'd0);
    fillWords(5, 2);
    enable = 1'b1;
    waitWords(3);
    cmpWord(0, 0, "R9 first valid word");
    cmpWord(1, 1, "R9 second valid word");
    cmpWord(2, 1, "R9 valid on repeat");

    // R7: external clock.
    doReset(9);
    extClkSel = 1'b1;
    extMode = 1'b1;
    fillWords(9, 2);
    extRun = 1'b1;
    enable = 1'b1;
    cycles(3);
    check(sclkOe == 1'b0, "R7 clock not driven", 64'(sclkOe), 64'd0);
    waitWords(3);
    check(sclkOut == 1'b0, "R7 generated clock idle", 64'(sclkOut), 64'd0);
    cmpWord(0, 0, "R7 external word 0");
    cmpWord(1, 1, "R7 external word 1");
    check(period == 12, "R7 follows external clock", 64'(period), 64'd12);
    check(fsDouble == 0, "R4 frame sync width external", 64'(fsDouble), 64'd0);
    extRun = 1'b0;
    enable = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule